// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

A single-word message slot that lets a producer clocked by one clock hand a 36-bit word to a consumer clocked by another. It sits beside a data queue and does not pass through it. The producer stores a word through port A. An active-low "mail waiting" flag then tells port B that a word is ready. When port B reads the slot, the flag clears. That clear is carried back to port A, which may then post the next word.

Each side keeps its own view of the flag, and each view is registered in its own clock. The write event and the read event each travel to the other domain as a toggle through a short synchronizer chain, so every event is seen exactly once. While mail is pending, the stored word cannot be overwritten. Port B's read data comes through a multiplexer. The port-B mailbox-select input picks either the slot contents or the word supplied on the queue data input.

Top module: `mailbox_xclk`

## Requirements
- R1: After reset, both flag outputs `a_mail_n` and `b_mail_n` are high, and the stored word is zero.
- R2: A port-A transfer is qualified when `a_sel_n`=0, `a_en`=1 and `a_mbox`=1 at a rising `clk_a` edge. If `a_mail_n` is high, that edge stores `a_wdata` and drives `a_mail_n` low.
- R3: At a `clk_a` edge where any of the three port-A qualifiers is inactive, nothing is stored, and both flags stay high.
- R4: While `a_mail_n` is low, a qualified port-A write is ignored, and the stored word is unchanged.
- R5: After a stored write, `b_mail_n` goes low within 8 `clk_b` cycles.
- R6: A port-B read is qualified when `b_sel_n`=0, `b_en`=1 and `b_mbox`=1 at a rising `clk_b` edge. If `b_mail_n` is low, that edge drives `b_mail_n` high.
- R7: At a `clk_b` edge where any of the three port-B qualifiers is inactive, a low `b_mail_n` stays low.
- R8: After a clearing read, `a_mail_n` returns high within 8 `clk_a` cycles, and the next write is accepted.
- R9: `b_rdata` equals the stored word while `b_mbox`=1, and equals `fifo_rdata` while `b_mbox`=0.
- R10: Once cleared, `b_mail_n` stays high until another word is stored. Each write raises exactly one mail event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| rst_a_n | input | 1 | Write-side synchronous reset, active low |
| a_sel_n | input | 1 | Port-A select, active low |
| a_en | input | 1 | Port-A enable |
| a_mbox | input | 1 | Port-A mailbox select |
| a_wdata | input | W (36) | Word to post |
| a_mail_n | output | 1 | Write-side view of the flag, low while mail is unread |
| clk_b | input | 1 | Read-side clock |
| rst_b_n | input | 1 | Read-side synchronous reset, active low |
| b_sel_n | input | 1 | Port-B select, active low |
| b_en | input | 1 | Port-B enable |
| b_mbox | input | 1 | Port-B mailbox select, also steers `b_rdata` |
| fifo_rdata | input | W (36) | Queue data to pass when the mailbox is not selected |
| b_rdata | output | W (36) | Port-B read data |
| b_mail_n | output | 1 | Read-side view of the flag, low while mail is waiting |

## Verification
Some rules are checked on every edge of the relevant clock: a qualified write sets the write-side flag, unqualified cycles leave the flags alone, a pending word never changes, a qualified read clears the read-side flag, and unqualified reads keep it low. Other behaviour spans both domains and only the bench scenarios can show it. This covers the latency bound in each crossing, the return of write permission, the single event per write, and the content of `b_rdata` under both multiplexer settings. The bench covers all eight qualifier combinations on each port and a series of bit patterns across the full word.

// File: rtl/mbox_pkg.sv
// Package: shared defaults and the port qualification rule used by both sides.
// Assumes: select is active low, enable active high, mailbox select active high.
package mbox_pkg;
    localparam int unsigned DATA_W_DEF      = 36;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // True when a port performs a mailbox transfer on this edge.
    function automatic logic mbox_xfer(input logic sel_n, input logic en, input logic mbox);
        return (!sel_n) && en && mbox;
    endfunction
endpackage

// File: rtl/mbox_toggle_sync.sv
// Module: carries a toggle level into a destination clock domain and emits a
// one-cycle pulse for each change it sees.
// Assumes: the source toggles at most once per round trip of the handshake, so
// no change is lost; STAGES >= 2 for metastability settling.
module mbox_toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    localparam int unsigned LAST = STAGES;

    logic [LAST:0] chain_q;

    // Shift the toggle level through the synchronizer plus one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], tgl_in};
    end

    assign pulse = chain_q[LAST] ^ chain_q[LAST-1];
endmodule

// File: rtl/mbox_wr_side.sv
// Module: write-domain half. Holds the stored word, the write-side flag and the
// write event toggle; clears the flag when the read acknowledge arrives.
// Assumes: ack_pulse is already synchronized to clk.
module mbox_wr_side #(
    parameter int unsigned W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         en,
    input  logic         mbox,
    input  logic [W-1:0] wdata,
    input  logic         ack_pulse,
    output logic [W-1:0] word_q,
    output logic         wr_tgl,
    output logic         mail_n
);
    import mbox_pkg::*;

    logic accept;
    assign accept = mbox_xfer(sel_n, en, mbox) && mail_n;

    // Capture the word only when the slot is free.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (accept) word_q <= wdata;
    end

    // Flip the event toggle once per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_tgl <= 1'b0;
        else if (accept) wr_tgl <= ~wr_tgl;
    end

    // Flag low on a write, high again when the read comes back.
    always_ff @(posedge clk) begin
        if (!rst_n)         mail_n <= 1'b1;
        else if (accept)    mail_n <= 1'b0;
        else if (ack_pulse) mail_n <= 1'b1;
    end
endmodule

// File: rtl/mbox_rd_side.sv
// Module: read-domain half. Keeps the read-side flag, sets it low on each
// arriving mail event and clears it on a qualified read, flipping the ack toggle.
// Assumes: mail_pulse is already synchronized to clk.
module mbox_rd_side (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic en,
    input  logic mbox,
    input  logic mail_pulse,
    output logic rd_tgl,
    output logic mail_n
);
    import mbox_pkg::*;

    logic take;
    assign take = mbox_xfer(sel_n, en, mbox) && !mail_n;

    // Flip the acknowledge toggle once per clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)    rd_tgl <= 1'b0;
        else if (take) rd_tgl <= ~rd_tgl;
    end

    // Flag low on arriving mail, high on the read that consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)          mail_n <= 1'b1;
        else if (mail_pulse) mail_n <= 1'b0;
        else if (take)       mail_n <= 1'b1;
    end
endmodule

// File: rtl/mbox_out_mux.sv
// Module: port-B read data selector between the mailbox word and queue data.
// Assumes: the mailbox word is held steady while mail is pending.
module mbox_out_mux #(
    parameter int unsigned W = 36
) (
    input  logic         pick_mbox,
    input  logic [W-1:0] mbox_word,
    input  logic [W-1:0] queue_word,
    output logic [W-1:0] dout
);
    // Per-bit two-way select.
    always_comb begin
        for (int i = 0; i < W; i++) dout[i] = pick_mbox ? mbox_word[i] : queue_word[i];
    end
endmodule

// File: rtl/mailbox_xclk.sv
// Module: top of the cross-clock mailbox. Wires the write half, the read half,
// the two toggle synchronizers and the port-B output selector.
// Assumes: both resets are asserted together long enough for several edges of
// each clock; the stored word only changes while the read side is not using it.
module mailbox_xclk #(
    parameter int unsigned W           = mbox_pkg::DATA_W_DEF,
    parameter int unsigned SYNC_STAGES = mbox_pkg::SYNC_STAGES_DEF
) (
    input  logic         clk_a,
    input  logic         rst_a_n,
    input  logic         a_sel_n,
    input  logic         a_en,
    input  logic         a_mbox,
    input  logic [W-1:0] a_wdata,
    output logic         a_mail_n,
    input  logic         clk_b,
    input  logic         rst_b_n,
    input  logic         b_sel_n,
    input  logic         b_en,
    input  logic         b_mbox,
    input  logic [W-1:0] fifo_rdata,
    output logic [W-1:0] b_rdata,
    output logic         b_mail_n
);
    logic [W-1:0] word_q;
    logic         wr_tgl, rd_tgl;
    logic         mail_pulse_b, ack_pulse_a;

    mbox_wr_side #(.W(W)) u_wr (
        .clk(clk_a), .rst_n(rst_a_n), .sel_n(a_sel_n), .en(a_en), .mbox(a_mbox),
        .wdata(a_wdata), .ack_pulse(ack_pulse_a), .word_q(word_q),
        .wr_tgl(wr_tgl), .mail_n(a_mail_n)
    );

    mbox_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_mail (
        .clk(clk_b), .rst_n(rst_b_n), .tgl_in(wr_tgl), .pulse(mail_pulse_b)
    );

    mbox_rd_side u_rd (
        .clk(clk_b), .rst_n(rst_b_n), .sel_n(b_sel_n), .en(b_en), .mbox(b_mbox),
        .mail_pulse(mail_pulse_b), .rd_tgl(rd_tgl), .mail_n(b_mail_n)
    );

    mbox_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk_a), .rst_n(rst_a_n), .tgl_in(rd_tgl), .pulse(ack_pulse_a)
    );

    mbox_out_mux #(.W(W)) u_mux (
        .pick_mbox(b_mbox), .mbox_word(word_q), .queue_word(fifo_rdata), .dout(b_rdata)
    );
endmodule

// File: rtl/mbox_checker.sv
// Module: protocol checks for mailbox_xclk, attached through bind.
// Assumes: sees the top's ports and the stored word.
module mbox_checker #(
    parameter int unsigned W = 36
) (
    input logic         clk_a,
    input logic         rst_a_n,
    input logic         a_sel_n,
    input logic         a_en,
    input logic         a_mbox,
    input logic         a_mail_n,
    input logic [W-1:0] word_q,
    input logic         clk_b,
    input logic         rst_b_n,
    input logic         b_sel_n,
    input logic         b_en,
    input logic         b_mbox,
    input logic         b_mail_n
);
    logic wq, rq;
    assign wq = (!a_sel_n) && a_en && a_mbox;
    assign rq = (!b_sel_n) && b_en && b_mbox;

    assert_write_sets_flag_R2: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (wq && a_mail_n) |=> !a_mail_n);

    assert_idle_keeps_flag_R3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!wq && a_mail_n) |=> a_mail_n);

    assert_pending_word_stable_R4: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!a_mail_n) |=> $stable(word_q));

    assert_read_clears_flag_R6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (rq && !b_mail_n) |=> b_mail_n);

    assert_unqualified_read_holds_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!rq && !b_mail_n) |=> !b_mail_n);
endmodule

bind mailbox_xclk mbox_checker #(.W(W)) u_chk (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .a_sel_n(a_sel_n), .a_en(a_en), .a_mbox(a_mbox),
    .a_mail_n(a_mail_n), .word_q(word_q),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .b_sel_n(b_sel_n), .b_en(b_en), .b_mbox(b_mbox),
    .b_mail_n(b_mail_n)
);

// File: tb/sim_mailbox_xclk.sv
// Bench: sweeps qualifier combinations on both ports and a set of word patterns.
module sim_mailbox_xclk;
    localparam int W            = 36;
    localparam int CLK_PERIOD   = 10;
    localparam int CLK_B_PERIOD = 14;
    localparam int BOUND        = 8;

    logic clk_a = 0, clk_b = 0;
    logic rst_a_n = 0, rst_b_n = 0;
    logic a_sel_n = 1, a_en = 0, a_mbox = 0;
    logic b_sel_n = 1, b_en = 0, b_mbox = 0;
    logic [W-1:0] a_wdata = '0, fifo_rdata = '0;
    logic [W-1:0] b_rdata;
    logic a_mail_n, b_mail_n;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2)   clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

    mailbox_xclk #(.W(W), .SYNC_STAGES(2)) u0 (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_sel_n(a_sel_n), .a_en(a_en), .a_mbox(a_mbox),
        .a_wdata(a_wdata), .a_mail_n(a_mail_n),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .b_sel_n(b_sel_n), .b_en(b_en), .b_mbox(b_mbox),
        .fifo_rdata(fifo_rdata), .b_rdata(b_rdata), .b_mail_n(b_mail_n)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One port-A cycle with given qualifiers, then back to idle; samples after the edge.
    task automatic a_cycle(input logic s, input logic e, input logic m, input logic [W-1:0] d);
        @(negedge clk_a); a_sel_n = s; a_en = e; a_mbox = m; a_wdata = d;
        @(negedge clk_a); a_sel_n = 1; a_en = 0; a_mbox = 0;
    endtask

    // One port-B cycle; b_mbox is left selecting the mailbox afterwards.
    task automatic b_cycle(input logic s, input logic e, input logic m);
        @(negedge clk_b); b_sel_n = s; b_en = e; b_mbox = m;
        @(negedge clk_b); b_sel_n = 1; b_en = 0; b_mbox = 1;
    endtask

    // Count clk_b cycles until b_mail_n reaches val, up to BOUND.
    task automatic wait_b(input logic val, output int n);
        n = 0;
        while (b_mail_n !== val && n <= BOUND) begin @(negedge clk_b); n++; end
    endtask

    task automatic wait_a(input logic val, output int n);
        n = 0;
        while (a_mail_n !== val && n <= BOUND) begin @(negedge clk_a); n++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk_a);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] d, prev;
        int n;
        repeat (4) @(negedge clk_b);
        rst_a_n = 1; rst_b_n = 1;
        @(negedge clk_a);
        // R1: reset state
        chk(a_mail_n === 1'b1, "R1 a_mail_n", W'(a_mail_n), W'(1));
        chk(b_mail_n === 1'b1, "R1 b_mail_n", W'(b_mail_n), W'(1));
        b_mbox = 1; #1;
        chk(b_rdata === '0, "R1 stored word", b_rdata, '0);

        // R3: all seven unqualified port-A combinations
        for (int c = 0; c < 8; c++) begin
            if (c == 3'b011) continue; // sel_n=0,en=1,mbox=1 is the qualified one
            a_cycle(c[2], c[1], c[0], 36'hF0F0F0F0F);
            chk(a_mail_n === 1'b1, $sformatf("R3 combo %0d a_mail_n", c), W'(a_mail_n), W'(1));
        end
        repeat (BOUND) @(negedge clk_b);
        chk(b_mail_n === 1'b1, "R3 b_mail_n", W'(b_mail_n), W'(1));
        chk(b_rdata === '0, "R3 word unchanged", b_rdata, '0);

        prev = '0;
        for (int i = 0; i < 14; i++) begin
            d = (i % 2 == 0) ? (W'(1) << (i * 5 % W)) : ~(W'(1) << (i * 7 % W));
            if (i == 13) d = {W{1'b1}};
            a_cycle(0, 1, 1, d);
            chk(a_mail_n === 1'b0, "R2 a_mail_n low", W'(a_mail_n), '0);
            wait_b(1'b0, n);
            chk(n <= BOUND, "R5 b_mail_n low in bound", W'(n), W'(BOUND));
            b_mbox = 1; #1;
            chk(b_rdata === d, "R2/R9 stored word", b_rdata, d);

            // R4: write attempt while pending
            a_cycle(0, 1, 1, ~d ^ W'(i));
            #1;
            chk(b_rdata === d, "R4 word kept", b_rdata, d);

            if (i == 0) begin
                for (int c = 0; c < 8; c++) begin
                    if (c == 3'b011) continue;
                    b_cycle(c[2], c[1], c[0]);
                    chk(b_mail_n === 1'b0, $sformatf("R7 combo %0d", c), W'(b_mail_n), '0);
                end
            end

            // R9: queue path
            @(negedge clk_b); b_mbox = 0; fifo_rdata = ~d ^ W'(i * 3); #1;
            chk(b_rdata === (~d ^ W'(i * 3)), "R9 queue data", b_rdata, ~d ^ W'(i * 3));
            b_mbox = 1;

            b_cycle(0, 1, 1);
            chk(b_mail_n === 1'b1, "R6 b_mail_n high", W'(b_mail_n), W'(1));
            wait_a(1'b1, n);
            chk(n <= BOUND, "R8 a_mail_n high in bound", W'(n), W'(BOUND));
            repeat (BOUND + 2) @(negedge clk_b);
            chk(b_mail_n === 1'b1, "R10 no second event", W'(b_mail_n), W'(1));
            prev = d;
        end
        chk(b_rdata === prev, "R8 last word accepted", b_rdata, prev);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule